// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns a 32-bit virtual address into a physical address. The mapping is held in two levels of tables in memory, and pages are 4 KB. A requester presents a virtual address together with an access kind. The block first looks in a small fully associative cache of finished translations. On a miss it fetches one entry from the first-level directory and then one entry from the second-level table, using a read port that allows one read in flight at a time.

Each response carries either the physical address or a fault code, and it always echoes the virtual address. Permission checks run on every response, whether it came from the cache or from a walk. The cache only keeps translations that did not fault. Software selects the active address space by writing a base register, and every such write empties the cache.

Top module: `ptw_top`

## Requirements
- R1: The directory entry is fetched from {base[31:12], va[31:22], 2'b00}, that is, directory base plus the top index times 4. The low 12 bits written to the base register are ignored.
- R2: When the directory entry is present, the second fetch reads {dir_entry[31:12], va[21:12], 2'b00}.
- R3: A translation that does not fault returns {table_entry[31:12], va[11:0]} with fault code 0.
- R4: Entry format is: bits 31:12 hold the base, bit 0 is present, bit 1 is writable, bit 2 is executable. An absent directory entry ends the walk after one read with fault code 1. An absent table entry gives fault code 1 after two reads.
- R5: Access kinds are read=0, write=1, execute=2, and 3 is treated as read. The effective writable and executable rights are the AND of both levels. A write without the writable right gives fault code 2. An execute without the executable right gives fault code 3. A read of a present page never faults.
- R6: A translation that hits the cache returns the same physical address as a walk and makes no memory reads.
- R7: Permission checks apply to cached translations. A write to a page cached without the writable right gives fault code 2 with no memory reads.
- R8: A translation that faults is not stored. Repeating it walks again.
- R9: The cache holds TLB_ENTRIES translations tagged by va[31:12] and replaces them in round-robin order.
- R10: Writing the base register invalidates every cached translation before the next lookup.
- R11: req_ready is high only while no translation is in progress. rsp_valid is a single-cycle pulse per request. A memory request holds its address until it is accepted.
- R12: A response echoes the virtual address, and on a fault the physical address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr_en | input | 1 | Load the directory base and empty the cache |
| base_wr_data | input | 32 | New directory base; bits 11:0 are ignored |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, or zero on a fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 write denied, 3 execute denied |
| rsp_vaddr | output | 32 | Virtual address of the answered request |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry word |

## Verification
The bench builds the block with TLB_ENTRIES=4. With four entries, five distinct pages are enough to force an eviction, so the round-robin victim order can be observed through read counts. Two address spaces with computed table contents are used. Twelve directory indices, including the top ones, are crossed with six table indices and all three access kinds. Because the cache is emptied before each sweep access, every combination of absent, writable and executable entries at both levels is walked, and the fetch addresses can be checked against arithmetic.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFS_W   = 12;
  localparam int IDX_W   = 10;
  localparam int TAG_W   = ADDR_W - OFS_W;

  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_WR     = 2'd2,
    FLT_EX     = 2'd3
  } flt_e;

  typedef struct packed {
    logic [TAG_W-1:0] frame;
    logic             wr;
    logic             ex;
  } xlat_t;

  function automatic flt_e perm_check(logic [1:0] kind, logic wr, logic ex);
    if (kind == ACC_WRITE && !wr) return FLT_WR;
    if (kind == ACC_EXEC && !ex) return FLT_EX;
    return FLT_NONE;
  endfunction
endpackage

// File: rtl/ptw_tlb.sv
module ptw_tlb
  import ptw_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               ins_en,
  input  logic [TAG_W-1:0]   ins_tag,
  input  xlat_t              ins_data,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output xlat_t              lk_data,
  output logic [ENTRIES-1:0] vld
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, vld_d, match;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  xlat_t              data_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               do_ins;

  assign do_ins = ins_en && !flush;

  always_comb begin
    ptr_d = ptr_q;
    if (do_ins) ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic load;
    assign load     = do_ins && (ptr_q == PTR_W'(i));
    assign match[i] = vld_q[i] && (tag_q[i] == lk_tag);
    assign vld_d[i] = !flush && (vld_q[i] || load);

    always_ff @(posedge clk) begin
      if (load) begin
        tag_q[i]  <= ins_tag;
        data_q[i] <= ins_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_data = data_q[i];
    end
  end

  assign lk_hit = |match;
  assign vld    = vld_q;
endmodule

// File: rtl/ptw_walk.sv
module ptw_walk
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic [ADDR_W-1:0] rsp_vaddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_hit,
  input  xlat_t             lk_data,
  output logic              ins_en,
  output xlat_t             ins_data
);
  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_DREQ, S_DWAIT, S_TREQ, S_TWAIT} st_e;

  st_e               state_q, state_d;
  logic [ADDR_W-1:0] va_q;
  logic [1:0]        kind_q;
  logic [TAG_W-1:0]  tb_q;
  logic              pw_q, px_q;
  logic              rsp_v_q;
  logic [ADDR_W-1:0] rsp_pa_q, rsp_va_q;
  flt_e              rsp_fk_q;

  logic              accept, dir_ld, fin;
  flt_e              fin_fk;
  logic [TAG_W-1:0]  fin_frame;
  logic              unused_ok;

  assign unused_ok = ^{mem_rsp_data[OFS_W-1:3]};
  assign accept    = (state_q == S_IDLE) && req_valid;
  assign req_ready = (state_q == S_IDLE);
  assign lk_tag    = va_q[ADDR_W-1:OFS_W];
  assign ins_data  = '{frame: mem_rsp_data[ADDR_W-1:OFS_W],
                       wr: pw_q & mem_rsp_data[1],
                       ex: px_q & mem_rsp_data[2]};

  // next-state process
  always_comb begin
    state_d   = state_q;
    dir_ld    = 1'b0;
    fin       = 1'b0;
    fin_fk    = FLT_NONE;
    fin_frame = lk_data.frame;
    ins_en    = 1'b0;
    unique case (state_q)
      S_IDLE:  if (req_valid) state_d = S_LOOK;
      S_LOOK: begin
        if (lk_hit) begin
          fin    = 1'b1;
          fin_fk = perm_check(kind_q, lk_data.wr, lk_data.ex);
        end else begin
          state_d = S_DREQ;
        end
      end
      S_DREQ:  if (mem_req_ready) state_d = S_DWAIT;
      S_DWAIT: begin
        if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            fin    = 1'b1;
            fin_fk = FLT_ABSENT;
          end else begin
            dir_ld  = 1'b1;
            state_d = S_TREQ;
          end
        end
      end
      S_TREQ:  if (mem_req_ready) state_d = S_TWAIT;
      S_TWAIT: begin
        if (mem_rsp_valid) begin
          fin       = 1'b1;
          fin_frame = ins_data.frame;
          fin_fk    = mem_rsp_data[0] ? perm_check(kind_q, ins_data.wr, ins_data.ex)
                                      : FLT_ABSENT;
          ins_en    = (fin_fk == FLT_NONE);
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  always_comb begin
    mem_req_valid = (state_q == S_DREQ) || (state_q == S_TREQ);
    mem_req_addr  = (state_q == S_TREQ) ? {tb_q, va_q[OFS_W+IDX_W-1:OFS_W], 2'b00}
                                        : {dir_base, va_q[ADDR_W-1:OFS_W+IDX_W], 2'b00};
  end

  // register process: control with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rsp_v_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_v_q <= fin;
    end
  end

  // register process: datapath with clock enables
  always_ff @(posedge clk) begin
    if (accept) begin
      va_q   <= req_vaddr;
      kind_q <= req_kind;
    end
    if (dir_ld) begin
      tb_q <= mem_rsp_data[ADDR_W-1:OFS_W];
      pw_q <= mem_rsp_data[1];
      px_q <= mem_rsp_data[2];
    end
    if (fin) begin
      rsp_fk_q <= fin_fk;
      rsp_pa_q <= (fin_fk == FLT_NONE) ? {fin_frame, va_q[OFS_W-1:0]} : '0;
      rsp_va_q <= va_q;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_paddr = rsp_pa_q;
  assign rsp_fault = rsp_fk_q;
  assign rsp_vaddr = rsp_va_q;
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int TLB_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_wr_en,
  input  logic [31:0] base_wr_data,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_kind,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic [1:0]  rsp_fault,
  output logic [31:0] rsp_vaddr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  logic [1:0]             rst_sync_q;
  logic                   rst_n_s;
  logic [TAG_W-1:0]       base_q;
  logic [TAG_W-1:0]       lk_tag;
  logic                   lk_hit, ins_en;
  xlat_t                  lk_data, ins_data;
  logic [TLB_ENTRIES-1:0] tlb_vld;
  logic                   unused_ok;

  assign unused_ok = ^{base_wr_data[OFS_W-1:0]};

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)        base_q <= '0;
    else if (base_wr_en) base_q <= base_wr_data[ADDR_W-1:OFS_W];
  end

  ptw_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk(clk), .rst_n(rst_n_s), .flush(base_wr_en),
    .ins_en(ins_en), .ins_tag(lk_tag), .ins_data(ins_data),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data), .vld(tlb_vld)
  );

  ptw_walk u_walk (
    .clk(clk), .rst_n(rst_n_s), .dir_base(base_q),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_vaddr(rsp_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data),
    .ins_en(ins_en), .ins_data(ins_data)
  );
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               base_wr_en,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic [31:0]        rsp_paddr,
  input logic [1:0]         rsp_fault,
  input logic [31:0]        rsp_vaddr,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [31:0]        mem_req_addr,
  input logic [ENTRIES-1:0] tlb_vld
);
  // R11
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R1
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  // R12
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == 32'd0));

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[11:0] == rsp_vaddr[11:0]));

  // R10
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_en |=> (tlb_vld == '0));
endmodule

bind ptw_top ptw_chk #(.ENTRIES(TLB_ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .base_wr_en(base_wr_en), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .rsp_vaddr(rsp_vaddr), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .tlb_vld(tlb_vld)
);

// File: tb/ptw_top_tb_top.sv
module ptw_top_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [31:0] BASE0  = 32'h0080_0000;
  localparam logic [31:0] BASE1  = 32'h0090_0000;
  localparam logic [31:0] PT_ORG = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n, base_wr_en, req_valid, req_ready, rsp_valid;
  logic [31:0] base_wr_data, req_vaddr, rsp_paddr, rsp_vaddr, mem_req_addr, mem_rsp_data;
  logic [1:0]  req_kind, rsp_fault;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;

  int n_chk = 0, n_bad = 0, cyc = 0, nreads = 0, rbase = 0, cur_sp = 0;
  logic [31:0] alog [2];
  logic        got_ok, busy_seen, pulse_ok, done = 1'b0;
  logic [31:0] g_pa, g_va, g_a0, g_a1;
  logic [1:0]  g_fk;
  int          g_rd;

  always #2.5 clk = ~clk;

  ptw_top #(.TLB_ENTRIES(4)) dut_i (.*);

  function automatic logic [31:0] pde_word(int sp, int d);
    int pd = (d + sp * 7) % 1024;
    logic [31:0] ptb = PT_ORG + 32'(pd << 12);
    return {ptb[31:12], 9'd0, (d % 3) != 2, (d % 2) == 0, (d % 4) != 3};
  endfunction

  function automatic logic [31:0] pte_word(int pd, int t);
    logic [19:0] fr = 20'((pd * 1024 + t) ^ 32'h5A5A5);
    return {fr, 9'd0, (t % 3) == 0, (t % 2) == 1, (t % 5) != 4};
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    if (a >= BASE0 && a < BASE0 + 32'd4096) return pde_word(0, int'((a - BASE0) >> 2));
    if (a >= BASE1 && a < BASE1 + 32'd4096) return pde_word(1, int'((a - BASE1) >> 2));
    if (a >= PT_ORG && a < 32'h0050_0000)
      return pte_word(int'((a - PT_ORG) >> 12), int'((a >> 2) & 32'h3FF));
    return 32'd0;
  endfunction

  // memory responder: one read outstanding, ready gaps, latency 1..3 cycles
  initial begin
    int wait_c;
    logic pend;
    logic [31:0] paddr_p;
    pend = 1'b0; wait_c = 0; paddr_p = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (wait_c == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(paddr_p);
          pend = 1'b0;
        end else wait_c--;
      end
      mem_req_ready = !pend && !mem_rsp_valid && (cyc % 3 != 0);
      #2;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1'b1; paddr_p = mem_req_addr; wait_c = cyc % 3;
        if (nreads - rbase < 2) alog[nreads - rbase] = mem_req_addr;
        nreads++;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr_base(input int sp);
    @(negedge clk);
    base_wr_en = 1'b1;
    base_wr_data = (sp != 0 ? BASE1 : BASE0) | 32'h0000_0ABC; // R1: low bits ignored
    cur_sp = sp;
    @(negedge clk);
    base_wr_en = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input logic [1:0] kind);
    int w = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    alog[0] = '0; alog[1] = '0; rbase = nreads;
    req_vaddr = va; req_kind = kind; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = !req_ready;
    while (!rsp_valid && w < 400) begin @(negedge clk); w++; end
    got_ok = rsp_valid; g_pa = rsp_paddr; g_fk = rsp_fault; g_va = rsp_vaddr;
    g_rd = nreads - rbase; g_a0 = alog[0]; g_a1 = alog[1];
    @(negedge clk);
    pulse_ok = !rsp_valid;
  endtask

  // exp_rd < 0: expect a full walk and check its fetch addresses
  task automatic run_chk(input logic [31:0] va, input logic [1:0] kind,
                         input int exp_rd, input string rq_rd);
    int d = int'(va[31:22]), t = int'(va[21:12]), enrd, er;
    logic [31:0] e1, e2, ea0, ea1, epa;
    logic [1:0]  efk;
    string rq;
    ea0 = (cur_sp != 0 ? BASE1 : BASE0) + 32'(d * 4);
    ea1 = '0; epa = '0;
    e1 = pde_word(cur_sp, d);
    if (!e1[0]) begin efk = 2'd1; enrd = 1; end
    else begin
      ea1 = {e1[31:12], 12'd0} + 32'(t * 4);
      e2 = mem_word(ea1); enrd = 2;
      if (!e2[0]) efk = 2'd1;
      else if (kind == 2'd1 && !(e1[1] & e2[1])) efk = 2'd2;
      else if (kind == 2'd2 && !(e1[2] & e2[2])) efk = 2'd3;
      else begin efk = 2'd0; epa = {e2[31:12], va[11:0]}; end
    end
    rq = (efk == 2'd1) ? "R4" : (efk != 2'd0) ? "R5" : "R3";
    xlate(va, kind);
    chk(got_ok, "R11", "response seen", 32'(got_ok), 32'd1);
    chk(g_fk == efk, rq, "fault code", 32'(g_fk), 32'(efk));
    chk(g_pa == epa, (efk != 0) ? "R12" : rq, "paddr", g_pa, epa);
    chk(g_va == va, "R12", "vaddr echo", g_va, va);
    er = (exp_rd < 0) ? enrd : exp_rd;
    chk(g_rd == er, rq_rd, "memory reads", 32'(g_rd), 32'(er));
    if (exp_rd < 0) begin
      chk(g_a0 == ea0, "R1", "directory fetch addr", g_a0, ea0);
      if (enrd == 2) chk(g_a1 == ea1, "R2", "table fetch addr", g_a1, ea1);
    end
  endtask

  function automatic logic [31:0] mkva(int d, int t, int ofs);
    return {10'(d), 10'(t), 12'(ofs)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; base_wr_en = 1'b0; base_wr_data = '0;
    req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "reset req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R11", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R11", "reset mem_req_valid", 32'(mem_req_valid), 32'd0);

    // sweep: both spaces, emptied cache before each, all kinds
    for (int sp = 0; sp < 2; sp++) begin
      for (int di = 0; di < 12; di++) begin
        for (int ti = 0; ti < 6; ti++) begin
          for (int k = 0; k < 3; k++) begin
            int d = (di < 6) ? di : 1012 + di;
            int t = (ti < 5) ? ti : 1023;
            wr_base(sp);
            run_chk(mkva(d, t, (d * 37 + t * 13) & 4095), 2'(k), -1, "R4");
          end
        end
      end
    end
    // kind 3 behaves as read on a non-writable, non-executable page (R5)
    wr_base(0);
    run_chk(mkva(1, 2, 5), 2'd3, -1, "R5");

    // R11: busy during the walk, single-cycle response
    wr_base(0);
    run_chk(mkva(0, 3, 16), 2'd0, -1, "R11");
    chk(busy_seen, "R11", "req_ready low while busy", 32'(busy_seen), 32'd1);
    chk(pulse_ok, "R11", "rsp_valid one cycle", 32'(pulse_ok), 32'd1);

    // R6: hit returns same frame without reads
    run_chk(mkva(0, 3, 12'h7FF), 2'd2, 0, "R6");
    run_chk(mkva(0, 3, 0), 2'd1, 0, "R6");

    // R7: cached non-writable page still faults on write
    run_chk(mkva(0, 0, 8), 2'd0, -1, "R7");
    run_chk(mkva(0, 0, 8), 2'd1, 0, "R7");
    run_chk(mkva(0, 0, 9), 2'd2, 0, "R7");

    // R8: faulting walk is not stored
    run_chk(mkva(0, 1, 4), 2'd2, 2, "R8");
    run_chk(mkva(0, 1, 4), 2'd2, 2, "R8");
    run_chk(mkva(0, 1, 4), 2'd0, 2, "R8");
    run_chk(mkva(0, 1, 4), 2'd1, 0, "R8");

    // R9: round-robin over 4 entries
    wr_base(0);
    run_chk(mkva(0, 3, 1), 2'd0, 2, "R9");
    run_chk(mkva(0, 6, 1), 2'd0, 2, "R9");
    run_chk(mkva(0, 7, 1), 2'd0, 2, "R9");
    run_chk(mkva(0, 8, 1), 2'd0, 2, "R9");
    run_chk(mkva(0, 10, 1), 2'd0, 2, "R9");
    run_chk(mkva(0, 6, 2), 2'd0, 0, "R9");
    run_chk(mkva(0, 3, 2), 2'd0, 2, "R9");
    run_chk(mkva(0, 7, 2), 2'd0, 0, "R9");
    run_chk(mkva(0, 6, 3), 2'd0, 2, "R9");

    // R10: switching space drops cached translations
    run_chk(mkva(2, 3, 44), 2'd0, -1, "R10");
    run_chk(mkva(2, 3, 44), 2'd0, 0, "R10");
    wr_base(1);
    run_chk(mkva(2, 3, 44), 2'd0, -1, "R10");
    run_chk(mkva(0, 10, 1), 2'd0, -1, "R10");

    summary();
  end
endmodule